// File: doc/BRIEF.md
# Hazard-Switched Hardware Thread Scheduler

This block decides, every cycle, which of four hardware threads feeds the next instruction into a single-issue, in-order pipeline. It holds one fetch address and one two-bit status for each thread. The thread that is issuing keeps the pipeline until it reports an unresolvable data or control hazard, or until it writes its suspend control register. When that happens, a different thread's fetch address is on the output in that same cycle, so the switch costs no bubble. Stalled threads come back on their own after a fixed number of cycles. Suspended threads come back only when their external wake line is asserted. No interrupt is involved at any point.

Each thread is in one of four states. RUN means it is the issuing thread. READY means it can be picked. STALL means it is waiting out a hazard. SUSP means it is parked until woken. The transitions are as follows. RUN goes to STALL on a hazard (*hazard-out*). RUN goes to SUSP on a suspend write when no wake is pending (*park*). RUN goes to READY on a suspend write when a wake is pending (*pass-through*). READY goes to RUN when the thread is selected (*pick*). STALL goes to READY when its delay counter runs out (*resolve*). SUSP goes to READY when its wake line is high (*wake*). The scheduler itself has two modes. ISSUE means a thread is running. IDLE means no thread was eligible. ISSUE goes to IDLE when the leaving thread finds no successor (*starve*). IDLE goes to ISSUE as soon as any thread is READY (*resume*).

The hazard detector, register files, datapath and forwarding network sit outside this block. The hazard detector is seen here only as a strobe that refers to the issuing thread.

Top module: `hts_sched_top`

## Requirements
- R1: After reset, thread 0 is issuing (issue_valid_o=1, tid_o=0). Thread n's fetch address starts at BOOT_PC + n*BOOT_STRIDE (defaults 0 and 0x100). Threads 1 to 3 start READY.
- R2: While neither hazard_i nor suspend_i is high, the same thread keeps issuing. Its address grows by PC_STEP (default 4) after each cycle with advance_i=1, and holds when advance_i=0.
- R3: In a cycle where the issuing thread raises hazard_i and another thread is READY, tid_o and fetch_pc_o already show that other thread and issue_valid_o stays 1. advance_i in that cycle advances the newly shown thread. The hazarding thread's address is left unchanged, so the instruction is replayed.
- R4: The successor is searched round-robin starting at the index after the leaving thread and wrapping around. Threads in SUSP or STALL are skipped.
- R5: A thread that raised a hazard in cycle t cannot be selected in cycles t+1 to t+RESOLVE_DLY (default 2). It can be selected from cycle t+RESOLVE_DLY+1 onward.
- R6: redirect_valid_i loads redirect_pc_i into the address of the thread that was running at the start of the cycle, even when that thread is switched out in the same cycle. For that thread, the redirect takes priority over advance.
- R7: suspend_i parks the issuing thread, and a parked thread is never selected until it is woken.
- R8: wake_i[n] high while thread n is in SUSP makes it READY. It can then be selected in the next cycle, not in the cycle the wake line is high.
- R9: wake_i[n] high while thread n is not in SUSP is remembered as pending. Thread n's next suspend write then leaves it READY instead of parked, although it still gives up the pipeline.
- R10: When no thread is READY, issue_valid_o is 0. While idle, hazard_i, suspend_i and redirect_valid_i have no effect.
- R11: On leaving idle, the lowest-index READY thread is picked, whatever thread ran last.
- R12: If hazard_i and suspend_i are both high, the suspend wins and the thread is parked, not stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| hazard_i | input | 1 | Issuing thread has a hazard forwarding cannot resolve |
| redirect_valid_i | input | 1 | Branch redirect for the thread running at cycle start |
| redirect_pc_i | input | PC_W | Redirect target address |
| suspend_i | input | 1 | Issuing thread wrote its suspend control register |
| wake_i | input | NUM_THREADS | Per-thread external wake lines |
| advance_i | input | 1 | Advance the shown thread's address after this cycle |
| tid_o | output | TID_W | Thread selected for issue |
| fetch_pc_o | output | PC_W | Fetch address of the selected thread |
| issue_valid_o | output | 1 | A thread is issuing this cycle |

## Verification
The hardest state to reach from the ports is one where a round-robin search must step past a parked thread and a still-stalled thread before landing on a thread that only became eligible through a pending wake. The stimulus first raises a wake line while thread 0 is running. It then chains hazards and suspend writes so that thread 2 is parked and thread 3 is stalled. Thread 0 then suspends while its wake is pending, and one cycle later a hazard on thread 1 must select thread 0. Idle entry and exit are reached by parking or stalling every thread in turn. The lowest-index rule on resume is then separated from plain round-robin by making the last running thread sit just below a thread that would otherwise win.

// File: rtl/hts_pkg.sv
package hts_pkg;

    // Per-thread status
    typedef enum logic [1:0] {
        TS_RUN   = 2'd0,
        TS_READY = 2'd1,
        TS_STALL = 2'd2,
        TS_SUSP  = 2'd3
    } thr_state_e;

    // Scheduler mode
    typedef enum logic {
        M_ISSUE = 1'b0,
        M_IDLE  = 1'b1
    } sched_mode_e;

endpackage

// File: rtl/hts_rr_pick.sv
// Finds the first eligible thread, scanning upward from start_i with wraparound.
module hts_rr_pick #(
    parameter int N     = 4,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     elig_i,
    input  logic [IDX_W-1:0] start_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o
);

    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        // Scan from farthest to nearest so the nearest eligible thread wins.
        for (int k = N - 1; k >= 0; k--) begin
            int pos;
            pos = (int'(start_i) + k) % N;
            if (elig_i[pos]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(pos);
            end
        end
    end

endmodule

// File: rtl/hts_thread_slot.sv
// One thread context: status FSM, hazard delay counter, pending wake, fetch address.
module hts_thread_slot
    import hts_pkg::*;
#(
    parameter int              PC_W        = 32,
    parameter int              RESOLVE_DLY = 2,
    parameter int              CNT_W       = $clog2(RESOLVE_DLY + 1),
    parameter logic [PC_W-1:0] PC_STEP     = 4,
    parameter logic [PC_W-1:0] RESET_PC    = '0,
    parameter bit              BOOT_RUN    = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            leave_haz_i,   // running thread hazards out
    input  logic            leave_susp_i,  // running thread writes suspend
    input  logic            pick_i,        // selected as new running thread
    input  logic            wake_i,
    input  logic            adv_i,
    input  logic            redir_i,
    input  logic [PC_W-1:0] redir_pc_i,
    output thr_state_e      st_o,
    output logic [PC_W-1:0] pc_o
);

    thr_state_e      st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic            pend_q, pend_d;
    logic [PC_W-1:0] pc_q, pc_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= BOOT_RUN ? TS_RUN : TS_READY;
            cnt_q  <= '0;
            pend_q <= 1'b0;
            pc_q   <= RESET_PC;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            pend_q <= pend_d;
            pc_q   <= pc_d;
        end
    end

    // Next state
    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        pend_d = pend_q;
        if (wake_i && (st_q != TS_SUSP)) begin
            pend_d = 1'b1;
        end
        unique case (st_q)
            TS_RUN: begin
                if (leave_susp_i) begin
                    // pass-through when a wake is pending, otherwise park
                    st_d   = (pend_q || wake_i) ? TS_READY : TS_SUSP;
                    pend_d = 1'b0;
                end else if (leave_haz_i) begin
                    st_d  = TS_STALL;
                    cnt_d = CNT_W'(RESOLVE_DLY);
                end
            end
            TS_READY: begin
                if (pick_i) st_d = TS_RUN;
            end
            TS_STALL: begin
                if (cnt_q <= CNT_W'(1)) begin
                    st_d  = TS_READY;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            TS_SUSP: begin
                if (wake_i) st_d = TS_READY;
            end
            default: st_d = TS_READY;
        endcase
    end

    // Fetch address: redirect beats advance
    always_comb begin
        pc_d = pc_q;
        if (redir_i)     pc_d = redir_pc_i;
        else if (adv_i)  pc_d = pc_q + PC_STEP;
    end

    assign st_o = st_q;
    assign pc_o = pc_q;

    // R7: a parked thread with no wake stays parked
    a_r7_susp_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TS_SUSP && !wake_i) |=> (st_q == TS_SUSP));

    // R8: wake on a parked thread readies it at the next edge
    a_r8_wake_readies: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TS_SUSP && wake_i) |=> (st_q == TS_READY));

    // R5: a stalled thread only ever resolves to READY
    a_r5_stall_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TS_STALL) |=> (st_q == TS_STALL || st_q == TS_READY));

    // R12: suspend together with hazard never produces a stall
    a_r12_susp_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TS_RUN && leave_susp_i && leave_haz_i) |=> (st_q != TS_STALL));

endmodule

// File: rtl/hts_sched_top.sv
// Coarse-grained four-thread issue scheduler with zero-cycle switch on hazards.
module hts_sched_top
    import hts_pkg::*;
#(
    parameter int              NUM_THREADS = 4,
    parameter int              PC_W        = 32,
    parameter int              RESOLVE_DLY = 2,
    parameter logic [PC_W-1:0] PC_STEP     = 4,
    parameter logic [PC_W-1:0] BOOT_PC     = '0,
    parameter logic [PC_W-1:0] BOOT_STRIDE = 'h100,
    localparam int             TID_W       = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
    localparam int             CNT_W       = $clog2(RESOLVE_DLY + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   hazard_i,
    input  logic                   redirect_valid_i,
    input  logic [PC_W-1:0]        redirect_pc_i,
    input  logic                   suspend_i,
    input  logic [NUM_THREADS-1:0] wake_i,
    input  logic                   advance_i,
    output logic [TID_W-1:0]       tid_o,
    output logic [PC_W-1:0]        fetch_pc_o,
    output logic                   issue_valid_o
);

    sched_mode_e       mode_q, mode_d;
    logic [TID_W-1:0]  cur_q, cur_d;

    thr_state_e        st_vec [NUM_THREADS];
    logic [PC_W-1:0]   pc_vec [NUM_THREADS];
    logic [NUM_THREADS-1:0] rdy_vec, run_vec;
    logic [NUM_THREADS-1:0] is_cur, haz_vec, susp_vec, pick_vec, adv_vec, redir_vec;

    logic              leave, need_pick, found;
    logic [TID_W-1:0]  start_idx, cand;

    // Leaving only happens while a thread is actually issuing
    assign leave     = (mode_q == M_ISSUE) && (hazard_i || suspend_i);
    assign need_pick = (mode_q == M_IDLE) || leave;
    // Round-robin from the next index while issuing, lowest index when idle
    assign start_idx = (mode_q == M_IDLE) ? '0 :
                       (cur_q == TID_W'(NUM_THREADS - 1)) ? '0 : cur_q + 1'b1;

    hts_rr_pick #(
        .N     (NUM_THREADS),
        .IDX_W (TID_W)
    ) u_pick (
        .elig_i  (rdy_vec),
        .start_i (start_idx),
        .found_o (found),
        .idx_o   (cand)
    );

    // Scheduler state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= M_ISSUE;
            cur_q  <= '0;
        end else begin
            mode_q <= mode_d;
            cur_q  <= cur_d;
        end
    end

    // Scheduler outputs and transitions
    always_comb begin
        mode_d        = mode_q;
        cur_d         = cur_q;
        tid_o         = cur_q;
        issue_valid_o = 1'b0;
        unique case (mode_q)
            M_ISSUE: begin
                if (!leave) begin
                    issue_valid_o = 1'b1;
                end else if (found) begin
                    tid_o         = cand;
                    issue_valid_o = 1'b1;
                    cur_d         = cand;
                end else begin
                    mode_d = M_IDLE;         // starve
                end
            end
            M_IDLE: begin
                if (found) begin             // resume
                    tid_o         = cand;
                    issue_valid_o = 1'b1;
                    cur_d         = cand;
                    mode_d        = M_ISSUE;
                end
            end
            default: mode_d = M_IDLE;
        endcase
    end

    assign fetch_pc_o = pc_vec[tid_o];

    // Per-thread controls
    always_comb begin
        for (int n = 0; n < NUM_THREADS; n++) begin
            is_cur[n]    = (mode_q == M_ISSUE) && (cur_q == TID_W'(n));
            susp_vec[n]  = is_cur[n] && suspend_i;
            haz_vec[n]   = is_cur[n] && hazard_i && !suspend_i;
            pick_vec[n]  = need_pick && found && (cand == TID_W'(n));
            adv_vec[n]   = issue_valid_o && advance_i && (tid_o == TID_W'(n));
            redir_vec[n] = is_cur[n] && redirect_valid_i;
            rdy_vec[n]   = (st_vec[n] == TS_READY);
            run_vec[n]   = (st_vec[n] == TS_RUN);
        end
    end

    for (genvar g = 0; g < NUM_THREADS; g++) begin : g_slot
        hts_thread_slot #(
            .PC_W        (PC_W),
            .RESOLVE_DLY (RESOLVE_DLY),
            .CNT_W       (CNT_W),
            .PC_STEP     (PC_STEP),
            .RESET_PC    (BOOT_PC + PC_W'(g) * BOOT_STRIDE),
            .BOOT_RUN    (g == 0)
        ) u_slot (
            .clk          (clk),
            .rst_n        (rst_n),
            .leave_haz_i  (haz_vec[g]),
            .leave_susp_i (susp_vec[g]),
            .pick_i       (pick_vec[g]),
            .wake_i       (wake_i[g]),
            .adv_i        (adv_vec[g]),
            .redir_i      (redir_vec[g]),
            .redir_pc_i   (redirect_pc_i),
            .st_o         (st_vec[g]),
            .pc_o         (pc_vec[g])
        );
    end

    // R2: at most one thread is running at any time
    a_r2_one_running: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(run_vec));

    // R3: a hazard with a ready successor keeps issue alive on another thread
    a_r3_zero_cycle_switch: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_ISSUE && hazard_i && !suspend_i && (|rdy_vec))
        |-> (issue_valid_o && tid_o != cur_q));

    // R7: the issued thread is never parked or stalled
    a_r7_no_issue_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid_o |-> (st_vec[tid_o] != TS_SUSP && st_vec[tid_o] != TS_STALL));

    // R10: idle with nothing ready drives issue low
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_IDLE && !(|rdy_vec)) |-> !issue_valid_o);

endmodule

// File: tb/hts_sched_top_tb.sv
`timescale 1ns/100ps
module hts_sched_top_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        hazard_i, redirect_valid_i, suspend_i, advance_i;
    logic [31:0] redirect_pc_i;
    logic [3:0]  wake_i;
    logic [1:0]  tid_o;
    logic [31:0] fetch_pc_o;
    logic        issue_valid_o;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    hts_sched_top u_dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .hazard_i         (hazard_i),
        .redirect_valid_i (redirect_valid_i),
        .redirect_pc_i    (redirect_pc_i),
        .suspend_i        (suspend_i),
        .wake_i           (wake_i),
        .advance_i        (advance_i),
        .tid_o            (tid_o),
        .fetch_pc_o       (fetch_pc_o),
        .issue_valid_o    (issue_valid_o)
    );

    // Drive one cycle of inputs at the falling edge, then settle before checking
    task automatic drive(input logic hz, input logic su, input logic rv,
                         input logic [31:0] rpc, input logic [3:0] wk, input logic adv);
        @(negedge clk);
        hazard_i = hz; suspend_i = su; redirect_valid_i = rv;
        redirect_pc_i = rpc; wake_i = wk; advance_i = adv;
        #1;
    endtask

    task automatic chk(input string req, input logic ev, input logic [1:0] et,
                       input logic [31:0] ep);
        total++;
        if (issue_valid_o !== ev || (ev && (tid_o !== et || fetch_pc_o !== ep))) begin
            bad++;
            $display("FAIL %s: got valid=%0b tid=%0d pc=%h, expected valid=%0b tid=%0d pc=%h",
                     req, issue_valid_o, tid_o, fetch_pc_o, ev, et, ep);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        hazard_i = 0; suspend_i = 0; redirect_valid_i = 0;
        redirect_pc_i = '0; wake_i = '0; advance_i = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R1 reset state, R2 steady issue and advance
    task automatic t_reset_and_advance();
        do_reset();
        drive(0,0,0,0,4'h0,1); chk("R1 reset", 1, 0, 32'h0);
        drive(0,0,0,0,4'h0,1); chk("R2 advance", 1, 0, 32'h4);
        drive(0,0,0,0,4'h0,1); chk("R2 advance", 1, 0, 32'h8);
        drive(0,0,0,0,4'h0,0); chk("R2 advance", 1, 0, 32'hC);
        drive(0,0,0,0,4'h0,0); chk("R2 hold", 1, 0, 32'hC);
    endtask

    // R3 zero-cycle switch and replay of the hazarding thread
    task automatic t_switch();
        do_reset();
        drive(1,0,0,0,4'h0,1); chk("R3 switch", 1, 1, 32'h100);
        drive(0,0,0,0,4'h0,1); chk("R3 new thread advanced", 1, 1, 32'h104);
        drive(1,0,0,0,4'h0,0); chk("R3 switch", 1, 2, 32'h200);
        drive(1,0,0,0,4'h0,0); chk("R3 switch", 1, 3, 32'h300);
        drive(1,0,0,0,4'h0,0); chk("R3 replay address", 1, 0, 32'h0);
    endtask

    // R5 stall window, R10 idle and ignored inputs, R7 parked, R8 wake latency
    task automatic t_stall_idle();
        do_reset();
        drive(0,1,0,0,4'h0,0); chk("R7 park", 1, 1, 32'h100);
        drive(0,1,0,0,4'h0,0); chk("R7 park", 1, 2, 32'h200);
        drive(0,1,0,0,4'h0,0); chk("R7 park", 1, 3, 32'h300);
        drive(1,0,0,0,4'h0,0); chk("R10 starve", 0, 0, 0);
        drive(1,1,1,32'h555,4'h0,0); chk("R5 still stalled", 0, 0, 0);
        drive(0,0,0,0,4'h0,0); chk("R5 still stalled", 0, 0, 0);
        drive(0,0,0,0,4'h2,0); chk("R10 resume, redirect ignored", 1, 3, 32'h300);
        drive(1,0,0,0,4'h0,0); chk("R8 woken thread picked", 1, 1, 32'h100);
    endtask

    // R4 skip of parked and stalled threads, R9 pending wake
    task automatic t_skip_pending();
        do_reset();
        drive(0,0,0,0,4'h1,0); chk("R9 wake while running", 1, 0, 32'h0);
        drive(1,0,0,0,4'h0,0); chk("R4 switch", 1, 1, 32'h100);
        drive(1,0,0,0,4'h0,0); chk("R4 switch", 1, 2, 32'h200);
        drive(0,1,0,0,4'h0,0); chk("R7 park", 1, 3, 32'h300);
        drive(1,0,0,0,4'h0,0); chk("R5 resolved", 1, 0, 32'h0);
        drive(0,1,0,0,4'h0,0); chk("R9 pass-through", 1, 1, 32'h100);
        drive(1,0,0,0,4'h0,0); chk("R4 R9 skip to pending thread", 1, 0, 32'h0);
        drive(0,0,0,0,4'h0,0); chk("R2 stays", 1, 0, 32'h0);
    endtask

    // R6 redirect priority and redirect on switch-out
    task automatic t_redirect();
        do_reset();
        drive(0,0,1,32'h40,4'h0,1); chk("R6 before redirect", 1, 0, 32'h0);
        drive(0,0,0,0,4'h0,1);      chk("R6 redirect beats advance", 1, 0, 32'h40);
        drive(1,0,1,32'h80,4'h0,1); chk("R6 switch", 1, 1, 32'h100);
        drive(1,0,0,0,4'h0,0);      chk("R6 switch", 1, 2, 32'h200);
        drive(1,0,0,0,4'h0,0);      chk("R6 switch", 1, 3, 32'h300);
        drive(1,0,0,0,4'h0,0);      chk("R6 old thread redirected", 1, 0, 32'h80);
    endtask

    // R12 suspend wins over hazard
    task automatic t_precedence();
        do_reset();
        drive(1,1,0,0,4'h0,0); chk("R12 both", 1, 1, 32'h100);
        drive(1,0,0,0,4'h0,0); chk("R12 chain", 1, 2, 32'h200);
        drive(1,0,0,0,4'h0,0); chk("R12 chain", 1, 3, 32'h300);
        drive(1,0,0,0,4'h0,0); chk("R12 thread 0 parked", 0, 0, 0);
        drive(0,0,0,0,4'h0,0); chk("R12 resume", 1, 1, 32'h100);
    endtask

    // R11 lowest-index resume
    task automatic t_lowest();
        do_reset();
        drive(0,1,0,0,4'h0,0); chk("R11 setup", 1, 1, 32'h100);
        drive(0,1,0,0,4'h0,0); chk("R11 setup", 1, 2, 32'h200);
        drive(0,1,0,0,4'h0,0); chk("R11 setup", 1, 3, 32'h300);
        drive(0,1,0,0,4'h2,0); chk("R8 wake not same cycle", 0, 0, 0);
        drive(0,0,0,0,4'h0,0); chk("R8 woken", 1, 1, 32'h100);
        drive(0,1,0,0,4'h0,0); chk("R10 idle", 0, 0, 0);
        drive(0,0,0,0,4'h9,0); chk("R8 wake pending edge", 0, 0, 0);
        drive(0,0,0,0,4'h0,0); chk("R11 lowest index", 1, 0, 32'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got no finish, expected end of tests");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        t_reset_and_advance();
        t_switch();
        t_stall_idle();
        t_skip_pending();
        t_redirect();
        t_precedence();
        t_lowest();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule